// File: doc/BRIEF.md
# Parity-Protected DRAM Board Controller

This block connects a processor memory port to an array of thirty-six single-bit dynamic RAM devices. Each word in the array is 36 bits wide: 32 data bits and 4 check bits, one check bit for each byte. The port takes one request at a time. A write carries an address and a data word. A read carries only an address and gets the stored word back. Accepted write data is held in a data latch. In the same cycle its check bits are computed and held in a separate latch, and the two are driven to the array together.

One sequencer produces the row strobe, column strobe and write strobe for every access. The 20-bit word address is split into a 10-bit row, taken from the upper bits, and a 10-bit column, taken from the lower bits. Both go out on one shared 10-bit address bus. A free-running timer raises a refresh request at a fixed period. The sequencer serves it with a row-strobe-only cycle, using an internal row counter. A refresh that is pending wins over a new request. It never cuts into an access that is already under way.

On a read, the returned word goes into an output register. The same check-bit generator that serves writes then recomputes the byte parities. Any byte whose parity disagrees with its stored check bit is flagged in the cycle of the completion pulse.

Top module: `dram_ctl_top`

## Requirements
- R1: While reset is held and in the first cycle after it, dram_ras_n, dram_cas_n and dram_we_n are high, ack is low and req_ready is high.
- R2: When dram_ras_n falls, dram_addr carries the row, which is req_addr[19:10]. When dram_cas_n falls, dram_addr carries the column, which is req_addr[9:0]. dram_we_n is low only while dram_cas_n is low during a write.
- R3: A write drives data to dram_dout[31:0] and check bit i to dram_dout[32+i]. Check bit i is the even parity (XOR) of data bits [8i+7:8i].
- R4: A read returns on rdata, in its ack cycle, the 32 data bits held at the addressed location. rd_err is 0 when the stored check bits match.
- R5: In the ack cycle of a read, rd_err[i] is 1 exactly when the XOR of returned byte i differs from returned check bit i.
- R6: ack is a single-cycle pulse. It appears T_ASU+T_RCD+T_CAS clock edges after the edge on which req_valid and req_ready were both high.
- R7: A refresh is started once per REF_PERIOD cycles. A refresh cycle asserts the row strobe only, and dram_cas_n stays high throughout.
- R8: The refresh row starts at 0 after reset and goes up by one with each refresh. It wraps to 0 after 2^ROW_W refreshes.
- R9: A pending refresh is served before a waiting request, and no access is interrupted. Between acceptance and ack, each access has exactly one assertion of the row strobe.
- R10: dram_cas_n is low only while dram_ras_n is low. Between two row-strobe assertions, dram_ras_n stays high for at least T_PRE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address (row in upper half, column in lower half) |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted on this edge if req_valid is high |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with ack |
| rd_err | output | 4 | Per-byte check-bit mismatch, valid with ack of a read |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 1 | Column address strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dout | output | 36 | Word and check bits to the array |
| dram_din | input | 36 | Word and check bits from the array |

## Verification
The hardest situation to reach is a refresh becoming due while a request is already waiting at the port. Only then does the priority rule decide anything, and only then could a refresh cut into an access. The stimulus holds req_valid high through a long run of back-to-back writes spanning several refresh periods. It then counts the refresh cycles seen inside the run and the row-strobe assertions inside each access. Bad check bits cannot be produced through the port, so the behavioural array flips stored bits directly to drive the per-byte error flags.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_CAS,
    ST_PRE
  } seq_state_t;

  // even parity of one byte: 1 when the byte holds an odd number of ones
  function automatic logic byte_parity(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_PERIOD = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_take,
  output logic ref_pend
);
  localparam int CNT_W = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  logic [CNT_W-1:0] tick_cnt;
  logic             tick_wrap;

  assign tick_wrap = (tick_cnt == CNT_W'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ref_pend <= 1'b0;
    end else begin
      tick_cnt <= tick_wrap ? '0 : tick_cnt + 1'b1;
      if (tick_wrap)     ref_pend <= 1'b1;
      else if (ref_take) ref_pend <= 1'b0;
    end
  end

  // R7: a request, once raised, stays until the sequencer takes it
  a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_take |=> ref_pend);

endmodule

// File: rtl/dram_check_unit.sv
module dram_check_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   gen_in,
  output logic [DATA_W/8-1:0] gen_out
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign gen_out[b] = dram_pkg::byte_parity(gen_in[8*b +: 8]);
  end

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int T_ASU = 1,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_PRE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_cpu,
  input  logic                 start_ref,
  input  logic                 op_wr,
  input  logic [ROW_W-1:0]     row_in,
  input  logic [COL_W-1:0]     col_in,
  output logic                 idle,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [MUX_W-1:0]     mux_addr,
  output logic                 cap_rd,
  output logic                 ack
);
  import dram_pkg::*;

  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_M1  = (T_ASU > T_RCD) ? T_ASU : T_RCD;
  localparam int T_M2  = (T_CAS > T_PRE) ? T_CAS : T_PRE;
  localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W = $clog2(T_MAX + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_ref;
  logic [ROW_W-1:0] ref_row;
  logic             phase_last;
  logic             ref_done;

  assign phase_last = (cnt == '0);
  assign ref_done   = (state == ST_CAS) && phase_last && is_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      is_ref  <= 1'b0;
      ref_row <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ref) begin
            state  <= ST_ROW;
            is_ref <= 1'b1;
            cnt    <= CNT_W'(T_ASU - 1);
          end else if (start_cpu) begin
            state  <= ST_ROW;
            is_ref <= 1'b0;
            cnt    <= CNT_W'(T_ASU - 1);
          end
        end
        ST_ROW: begin
          if (phase_last) begin
            state <= ST_RAS;
            cnt   <= CNT_W'(T_RCD - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_RAS: begin
          if (phase_last) begin
            state <= ST_CAS;
            cnt   <= CNT_W'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_CAS: begin
          if (phase_last) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(T_PRE - 1);
            if (is_ref) ref_row <= ref_row + 1'b1;
            else        ack     <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          if (phase_last) state <= ST_IDLE;
          else            cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle     = (state == ST_IDLE);
    ras_n    = !((state == ST_RAS) || (state == ST_CAS));
    cas_n    = !((state == ST_CAS) && !is_ref);
    we_n     = !((state == ST_CAS) && !is_ref && op_wr);
    cap_rd   = (state == ST_CAS) && phase_last && !is_ref && !op_wr;
    if (state == ST_CAS) mux_addr = MUX_W'(col_in);
    else if (is_ref)     mux_addr = MUX_W'(ref_row);
    else                 mux_addr = MUX_W'(row_in);
  end

  // R10: column strobe only inside a row strobe
  a_r10_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R10: after the row strobe is released it stays released for a precharge
  a_r10_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  // R6: completion is a single pulse
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R8: the refresh row moves only when a refresh finishes
  a_r8_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_done |=> $stable(ref_row));
  // R7: a refresh cycle never opens a column
  a_r7_ras_only: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> cas_n);

endmodule

// File: rtl/dram_ctl_top.sv
module dram_ctl_top #(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int T_ASU      = 1,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_PRE      = 2,
  parameter int REF_PERIOD = 390
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          req_ready,
  output logic                          ack,
  output logic [DATA_W-1:0]             rdata,
  output logic [DATA_W/8-1:0]           rd_err,
  output logic                          dram_ras_n,
  output logic                          dram_cas_n,
  output logic                          dram_we_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DATA_W+DATA_W/8-1:0]    dram_dout,
  input  logic [DATA_W+DATA_W/8-1:0]    dram_din
);
  localparam int CHK_W  = DATA_W / 8;
  localparam int ADDR_W = ROW_W + COL_W;

  logic              seq_idle, ref_pend, ref_take, accept, cap_rd;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, gen_in;
  logic [CHK_W-1:0]  wchk_q, rchk_q, gen_chk;

  // one generator: fed from the port while idle, from the output register otherwise
  function automatic logic [CHK_W-1:0] word_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int b = 0; b < CHK_W; b++) c[b] = ^d[8*b +: 8];
    return c;
  endfunction

  assign req_ready = seq_idle && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_take  = seq_idle && ref_pend;
  assign gen_in    = seq_idle ? req_wdata : rdata_q;

  dram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_take(ref_take), .ref_pend(ref_pend));

  dram_check_unit #(.DATA_W(DATA_W)) u_check (
    .gen_in(gen_in), .gen_out(gen_chk));

  dram_cycle_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .T_ASU(T_ASU), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_cpu(accept), .start_ref(ref_take), .op_wr(wr_q),
    .row_in(addr_q[ADDR_W-1:COL_W]), .col_in(addr_q[COL_W-1:0]),
    .idle(seq_idle), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .mux_addr(dram_addr), .cap_rd(cap_rd), .ack(ack));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      wchk_q  <= '0;
      rdata_q <= '0;
      rchk_q  <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
        wchk_q  <= gen_chk;
      end
      if (cap_rd) begin
        rdata_q <= dram_din[DATA_W-1:0];
        rchk_q  <= dram_din[DATA_W +: CHK_W];
      end
    end
  end

  assign dram_dout = {wchk_q, wdata_q};
  assign rdata     = rdata_q;
  assign rd_err    = ack ? (gen_chk ^ rchk_q) : '0;

  // R3: the check-bit latch always matches the data latch when the array is written
  a_r3_latch_parity: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_dout[DATA_W +: CHK_W] == word_check(dram_dout[DATA_W-1:0]));
  // R2: the write strobe lives inside the column strobe
  a_r2_we_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);
  // R9: the port is closed whenever a refresh is waiting
  a_r9_ref_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !accept);

endmodule

// File: tb/dram_ctl_top_bench.sv
`timescale 1ns/1ps
module dram_ctl_top_bench;
  localparam int TA = 1, TR = 2, TC = 2, TP = 2, RP = 40;
  localparam int LAT = TA + TR + TC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, ack;
  logic [31:0] rdata;
  logic [3:0]  rd_err;
  logic        dram_ras_n, dram_cas_n, dram_we_n;
  logic [9:0]  dram_addr;
  logic [35:0] dram_dout;
  logic [35:0] dram_din = '0;

  int checks = 0, fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dram_ctl_top #(.T_ASU(TA), .T_RCD(TR), .T_CAS(TC), .T_PRE(TP), .REF_PERIOD(RP)) u_dram_ctl_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .ack(ack),
    .rdata(rdata), .rd_err(rd_err), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dout(dram_dout), .dram_din(dram_din));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_chk(input logic [31:0] d);
    logic [3:0] c;
    for (int b = 0; b < 4; b++) begin
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(d[8*b+i]);
      c[b] = (ones % 2) == 1;
    end
    return c;
  endfunction

  // behavioural array, sampled on the falling edge
  logic [35:0] arr [int];
  logic [31:0] shadow [int];
  logic ras_p = 1'b1, cas_p = 1'b1, cas_in_ras = 1'b0, cur_wr = 1'b0;
  logic [9:0] row_l = '0, col_l = '0;
  int ras_falls = 0, ref_cnt = 0, exp_ref_row = 0, high_run = 100;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_cas_n && dram_ras_n) chk(1'b0, "R10 cas without ras", 1, 0);
      if (!dram_we_n && (dram_cas_n || !cur_wr)) chk(1'b0, "R2 we outside write cas", 1, 0);
      if (!dram_ras_n && ras_p) begin
        chk(high_run >= TP, "R10 precharge", high_run, TP);
        row_l = dram_addr;
        cas_in_ras = 1'b0;
        ras_falls++;
      end
      if (dram_ras_n && !ras_p && !cas_in_ras) begin
        chk(int'(row_l) == exp_ref_row, "R8 refresh row", row_l, exp_ref_row);
        exp_ref_row = (exp_ref_row + 1) % 1024;
        ref_cnt++;
      end
      high_run = dram_ras_n ? high_run + 1 : 0;
      if (!dram_cas_n && cas_p) begin
        col_l = dram_addr;
        cas_in_ras = 1'b1;
        if (!dram_we_n) arr[int'({row_l, col_l})] = dram_dout;
      end
      if (!dram_cas_n) begin
        if (arr.exists(int'({row_l, col_l}))) dram_din = arr[int'({row_l, col_l})];
        else dram_din = '0;
      end
      ras_p = dram_ras_n;
      cas_p = dram_cas_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic cpu_op(input bit wr, input logic [19:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic [3:0] er);
    int lat, base;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) step();
    cur_wr = wr;
    base = ras_falls;
    step();
    req_valid = 1'b0;
    lat = 1;
    while (!ack && lat < 60) begin step(); lat++; end
    chk(lat == LAT + 1, "R6 ack latency", lat, LAT + 1);
    rd = rdata; er = rd_err;
    chk(ras_falls - base == 1, "R9 single ras per access", ras_falls - base, 1);
    chk(row_l == a[19:10] && col_l == a[9:0], "R2 row/col split", {row_l, col_l}, a);
    step();
    chk(!ack, "R6 ack width", ack, 0);
    if (wr) begin
      shadow[int'(a)] = d;
      chk(arr[int'(a)] == {model_chk(d), d}, "R3 stored word", arr[int'(a)], {model_chk(d), d});
    end
  endtask

  task automatic do_read(input logic [19:0] a, input logic [3:0] exp_err, input logic [31:0] flip);
    logic [31:0] rd, exp_d;
    logic [3:0] er;
    exp_d = (shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0) ^ flip;
    cpu_op(1'b0, a, 32'h0, rd, er);
    chk(rd == exp_d, "R4 read data", rd, exp_d);
    chk(er == exp_err, exp_err == 0 ? "R4 clean read flags" : "R5 error flags", er, exp_err);
  endtask

  initial begin
    logic [31:0] rd;
    logic [3:0]  er;
    int r0, t0, expn;
    logic [19:0] addrs [4];
    logic [31:0] datas [4];
    addrs = '{20'h00000, 20'hFFFFF, 20'h12345, 20'h80401};
    datas = '{32'h00000000, 32'hFFFFFFFF, 32'hA5C3_0F81, 32'h0102_0408};
    repeat (3) step();
    chk(dram_ras_n && dram_cas_n && dram_we_n && !ack, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, ack}, 4'b1110);
    rst_n = 1'b1;
    t0 = cyc;
    step();
    chk(dram_ras_n && dram_cas_n && dram_we_n && !ack && req_ready, "R1 after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, ack, req_ready}, 5'b11101);

    for (int i = 0; i < 4; i++) cpu_op(1'b1, addrs[i], datas[i], rd, er);
    for (int i = 3; i >= 0; i--) do_read(addrs[i], 4'b0000, 32'h0);
    do_read(20'h33333, 4'b0000, 32'h0);

    // R5: corrupt stored bits behind the controller
    cpu_op(1'b1, 20'h00ABC, 32'h1234_5678, rd, er);
    arr[int'(20'h00ABC)][34] = ~arr[int'(20'h00ABC)][34];
    do_read(20'h00ABC, 4'b0100, 32'h0);
    arr[int'(20'h00ABC)][34] = ~arr[int'(20'h00ABC)][34];
    arr[int'(20'h00ABC)] = arr[int'(20'h00ABC)] ^ 36'h0_0100_0001;
    do_read(20'h00ABC, 4'b1001, 32'h0100_0001);

    // R9: back-to-back writes spanning several refresh periods
    r0 = ref_cnt;
    for (int i = 0; i < 16; i++) cpu_op(1'b1, 20'(i * 4099), 32'h9E37_79B9 * (i + 1), rd, er);
    chk(ref_cnt - r0 >= 2, "R9 refresh wins during burst", ref_cnt - r0, 2);
    for (int i = 0; i < 16; i++) do_read(20'(i * 4099), 4'b0000, 32'h0);

    // R7/R8: idle long enough for the refresh row to wrap
    repeat (1024 * RP + 200) step();
    expn = (cyc - t0) / RP;
    chk(ref_cnt >= expn - 1 && ref_cnt <= expn, "R7 refresh rate", ref_cnt, expn);
    chk(exp_ref_row == ref_cnt % 1024, "R8 wrap count", exp_ref_row, ref_cnt % 1024);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule